// File: doc/BRIEF.md
# Free-Running Timer with Overflow Status Flag

This block is a 16-bit up-counter that runs one count per clock while its enable bit is set. When it rolls over from its all-ones value to zero, it gives out a one-cycle overflow pulse and sets a sticky status flag. The flag is bit 0 of an 8-bit control byte that sits on a small register bus. The other seven bits of that byte are plain read/write control bits, and bit 7 is the counter enable. Software can read and load the counter one byte at a time.

Software can clear the flag in two ways, and they behave differently when an overflow arrives in the same cycle.

- **Whole-byte write.** Writing the control byte with bit 0 low clears the flag at once. A rollover in that same cycle is discarded.
- **Bit-clear access.** This is a single strobe that the block carries out as a two-cycle internal read-modify-write. It clears one chosen bit. If the flag is the target and a rollover lands in either of the two cycles, the flag is left set.

Software that reads the flag, sees 1, and then issues a bit-clear therefore never loses an overflow.

Top module: `tmr_ovf_unit`

## Requirements
- R1: While rst_ni is low, and after it is released, the counter reads 0x0000, the control byte reads 0x00 and ovf_pulse_o is 0.
- R2: The counter adds one at each clock edge while bit 7 of the control byte is 1, and holds while that bit is 0. It carries from the low byte into the high byte.
- R3: When the counter is enabled at 0xFFFF and is not being loaded, ovf_pulse_o is 1 for exactly that cycle. At the next edge the counter becomes 0x0000 and the flag (bit 0 of the control byte at address 0) becomes 1.
- R4: A byte write to address 0 with wdata_i bit 0 equal to 0 clears the flag and loads bits 7..1 from wdata_i.
- R5: A byte write to address 0 with wdata_i bit 0 equal to 1 leaves the flag unchanged, whether it was 0 or 1, and loads bits 7..1.
- R6: A byte write to address 0 with bit 0 equal to 0 in the same cycle as a rollover leaves the flag at 0.
- R7: A bit-clear strobe with addr_i = 0 and bit index k clears bit k of the control byte two edges later. All other bits are unchanged.
- R8: When a bit-clear of bit 0 has a rollover in its first (read) cycle or its second (write) cycle, the flag is 1 after the access.
- R9: In the cycle after an accepted bit-clear strobe, wr_i and bclr_i are ignored.
- R10: rdata_o is combinational. Address 0 returns the control byte, 1 the counter low byte, 2 the counter high byte, and 3 returns 0x00.
- R11: A byte write to address 1 or 2 loads that counter byte. In that cycle the counter does not increment and no overflow pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register select: 0 control, 1 count low, 2 count high |
| wr_i | input | 1 | Byte write strobe |
| bclr_i | input | 1 | Bit-clear strobe (address 0 only) |
| bit_idx_i | input | 3 | Bit index for a bit-clear |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data |
| ovf_pulse_o | output | 1 | One-cycle rollover pulse |

## Verification
The bench times a whole-byte clear to land on the rollover cycle and expects the flag to be 0. A design that let the set win would leave it at 1. It then starts bit-clears so that the rollover falls first in the read cycle and then in the write cycle, and expects the flag to survive both times. A read-modify-write that wrote back a stale copy would drop the overflow in one of those cases. A byte write issued during the write cycle of a bit-clear must have no effect, which catches a design that lets that write overtake the access. Further cases catch a flag that can be set by software, a missing carry into the high byte, and a counter load that also increments.

// File: rtl/tmr_ovf_pkg.sv
package tmr_ovf_pkg;
  localparam int unsigned OPT_ADDR = 0;
  localparam int unsigned FLAG_BIT = 0;

  typedef struct packed {
    logic opt_wr;
    logic rmw_rd;
    logic rmw_wr;
  } bus_op_t;
endpackage

// File: rtl/tmr_bus_ctl.sv
module tmr_bus_ctl
  import tmr_ovf_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned NBYTES = 2,
  parameter int unsigned IDX_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              bclr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [IDX_W-1:0]  bit_idx_i,
  output bus_op_t           op_o,
  output logic [NBYTES-1:0] cnt_ld_o,
  output logic [IDX_W-1:0]  rmw_idx_o
);
  logic busy_q;
  logic sel_opt;

  assign sel_opt = (addr_i == ADDR_W'(OPT_ADDR));

  // bit-clear takes the bus over a byte write in the same cycle
  assign op_o.rmw_rd = bclr_i && sel_opt && !busy_q;
  assign op_o.opt_wr = wr_i && !bclr_i && sel_opt && !busy_q;
  assign op_o.rmw_wr = busy_q;

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane_ld
    assign cnt_ld_o[g] = wr_i && !bclr_i && !busy_q && (addr_i == ADDR_W'(g + 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      rmw_idx_o <= '0;
    end else begin
      busy_q <= op_o.rmw_rd;
      if (op_o.rmw_rd) rmw_idx_o <= bit_idx_i;
    end
  end

  // R7: read phase is always followed by the write phase
  p_rmw_follow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_o.rmw_rd |=> op_o.rmw_wr);
  // R9: write phase lasts one cycle, no back-to-back access accepted
  p_busy_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_o.rmw_wr |=> !op_o.rmw_wr);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned NBYTES = CNT_W / DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [NBYTES-1:0] ld_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, base;
  logic             any_ld;

  assign any_ld = |ld_i;
  // a load cycle freezes counting for the whole word
  assign base   = (en_i && !any_ld) ? cnt_q + CNT_W'(1) : cnt_q;
  assign wrap_o = en_i && !any_ld && (cnt_q == '1);

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign cnt_d[g*DATA_W +: DATA_W] = ld_i[g] ? wdata_i : base[g*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  p_wrap_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == '0));
  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !any_ld) |=> (cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1))));
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !any_ld) |=> $stable(cnt_q));
  p_load_nopulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_ld |-> !wrap_o);
endmodule

// File: rtl/tmr_opt_reg.sv
module tmr_opt_reg
  import tmr_ovf_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bus_op_t           op_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  rmw_idx_i,
  input  logic              set_i,
  output logic [DATA_W-1:0] opt_o
);
  logic [DATA_W-1:0] opt_q, opt_d, hold_q, mask;
  logic              seen_q;

  assign mask = ~(DATA_W'(1) << rmw_idx_i);

  always_comb begin
    opt_d = opt_q;
    opt_d[FLAG_BIT] = opt_q[FLAG_BIT] | set_i;
    if (op_i.opt_wr) begin
      opt_d = wdata_i;
      // software may only clear the flag; a clearing write beats a set
      opt_d[FLAG_BIT] = wdata_i[FLAG_BIT] & (opt_q[FLAG_BIT] | set_i);
    end else if (op_i.rmw_wr) begin
      opt_d = hold_q & mask;
      // a set seen in either phase survives the write-back
      opt_d[FLAG_BIT] = opt_d[FLAG_BIT] | seen_q | set_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opt_q  <= '0;
      hold_q <= '0;
      seen_q <= 1'b0;
    end else begin
      opt_q  <= opt_d;
      seen_q <= op_i.rmw_rd & set_i;
      if (op_i.rmw_rd) hold_q <= opt_q;
    end
  end

  assign opt_o = opt_q;

  p_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !op_i.opt_wr) |=> opt_q[FLAG_BIT]);
  p_wr_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i.opt_wr && !wdata_i[FLAG_BIT]) |=> !opt_q[FLAG_BIT]);
  p_wr_noset_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i.opt_wr && wdata_i[FLAG_BIT] && !set_i) |=> (opt_q[FLAG_BIT] == $past(opt_q[FLAG_BIT])));
  p_clash_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i.opt_wr && !wdata_i[FLAG_BIT] && set_i) |=> !opt_q[FLAG_BIT]);
  p_rmw_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i.rmw_wr && rmw_idx_i == '0 && !seen_q && !set_i) |=> !opt_q[FLAG_BIT]);
  p_rmw_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i.rmw_wr && (seen_q || set_i)) |=> opt_q[FLAG_BIT]);
endmodule

// File: rtl/tmr_ovf_unit.sv
module tmr_ovf_unit
  import tmr_ovf_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 2,
  localparam int unsigned NBYTES = CNT_W / DATA_W,
  localparam int unsigned IDX_W  = $clog2(DATA_W),
  localparam int unsigned EN_BIT = DATA_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              bclr_i,
  input  logic [IDX_W-1:0]  bit_idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ovf_pulse_o
);
  bus_op_t           op;
  logic [NBYTES-1:0] cnt_ld;
  logic [IDX_W-1:0]  rmw_idx;
  logic [DATA_W-1:0] opt;
  logic [CNT_W-1:0]  cnt;
  logic              wrap;

  tmr_bus_ctl #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .IDX_W(IDX_W)) u_ctl (
    .clk_i, .rst_ni, .wr_i, .bclr_i, .addr_i, .bit_idx_i,
    .op_o(op), .cnt_ld_o(cnt_ld), .rmw_idx_o(rmw_idx)
  );

  tmr_counter #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cnt (
    .clk_i, .rst_ni, .en_i(opt[EN_BIT]), .ld_i(cnt_ld), .wdata_i,
    .cnt_o(cnt), .wrap_o(wrap)
  );

  tmr_opt_reg #(.DATA_W(DATA_W)) u_opt (
    .clk_i, .rst_ni, .op_i(op), .wdata_i, .rmw_idx_i(rmw_idx),
    .set_i(wrap), .opt_o(opt)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OPT_ADDR)) rdata_o = opt;
    for (int i = 0; i < NBYTES; i++) begin
      if (addr_i == ADDR_W'(i + 1)) rdata_o = cnt[i*DATA_W +: DATA_W];
    end
  end

  assign ovf_pulse_o = wrap;

  // R3: pulse never lasts two cycles
  p_pulse_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_pulse_o |=> !ovf_pulse_o);
  // R1: reset state
  p_reset_r1: assert property (@(posedge clk_i) !rst_ni |=> (opt == '0 && cnt == '0));
endmodule

// File: tb/tmr_ovf_unit_test.sv
`timescale 1ns/1ps
module tmr_ovf_unit_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] addr_i = '0;
  logic       wr_i = 1'b0;
  logic       bclr_i = 1'b0;
  logic [2:0] bit_idx_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       ovf_pulse_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  tmr_ovf_unit uut (.*);

  typedef struct packed {
    logic       rd;
    logic [1:0] addr;
    logic [7:0] data;
    logic [3:0] req;
  } vec_t;

  // counter disabled throughout; req column names the requirement checked
  localparam vec_t VEC [12] = '{
    '{1'b0, 2'd0, 8'h2A, 4'd4},  // R4 write control
    '{1'b1, 2'd0, 8'h2A, 4'd4},  // R4 read back
    '{1'b0, 2'd0, 8'h7F, 4'd5},  // R5 bit0=1 cannot set
    '{1'b1, 2'd0, 8'h7E, 4'd5},
    '{1'b0, 2'd1, 8'h34, 4'd11}, // R11 load low
    '{1'b0, 2'd2, 8'h12, 4'd11}, // R11 load high
    '{1'b1, 2'd1, 8'h34, 4'd10}, // R10 read low
    '{1'b1, 2'd2, 8'h12, 4'd10}, // R10 read high
    '{1'b1, 2'd3, 8'h00, 4'd10}, // R10 unused address
    '{1'b0, 2'd0, 8'h00, 4'd4},
    '{1'b1, 2'd0, 8'h00, 4'd4},
    '{1'b1, 2'd1, 8'h34, 4'd2}   // R2 held while disabled
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // all bus tasks start and end near a falling edge
  task automatic do_write(input logic [1:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic do_bclr(input logic [2:0] k);
    addr_i = 2'd0; bit_idx_i = k; bclr_i = 1'b1;
    @(negedge clk_i);
    bclr_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
    addr_i = a;
    #1;
    check(req, rdata_o, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rd_chk("R1", 2'd0, 8'h00);
    rd_chk("R1", 2'd1, 8'h00);
    check("R1", {7'd0, ovf_pulse_o}, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd_chk("R1", 2'd2, 8'h00);

    foreach (VEC[i]) begin
      if (VEC[i].rd) rd_chk($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].addr, VEC[i].data);
      else           do_write(VEC[i].addr, VEC[i].data);
    end

    // R2 counting for six edges from 0x0010
    do_write(2'd1, 8'h10); do_write(2'd2, 8'h00);
    do_write(2'd0, 8'h80);
    repeat (5) @(negedge clk_i);
    do_write(2'd0, 8'h00);
    rd_chk("R2 count", 2'd1, 8'h16);
    rd_chk("R2 count", 2'd2, 8'h00);
    // R2 carry into high byte
    do_write(2'd1, 8'hFF);
    do_write(2'd0, 8'h80);
    do_write(2'd0, 8'h00);
    rd_chk("R2 carry", 2'd2, 8'h01);
    rd_chk("R2 carry", 2'd1, 8'h00);
    // R11 load while enabled suppresses the increment
    do_write(2'd0, 8'h80);
    do_write(2'd1, 8'h40);
    rd_chk("R11 load", 2'd1, 8'h40);
    do_write(2'd0, 8'h00);
    rd_chk("R11 resume", 2'd1, 8'h41);

    // R3 plain rollover
    do_write(2'd1, 8'hFF); do_write(2'd2, 8'hFF);
    do_write(2'd0, 8'h80);
    check("R3 pulse", {7'd0, ovf_pulse_o}, 8'h01);
    @(negedge clk_i);
    check("R3 pulse width", {7'd0, ovf_pulse_o}, 8'h00);
    rd_chk("R3 flag", 2'd0, 8'h81);
    rd_chk("R3 wrap", 2'd2, 8'h00);
    do_write(2'd0, 8'h01);
    rd_chk("R5 keep set", 2'd0, 8'h01);

    // R6 byte clear on the rollover cycle loses it
    do_write(2'd1, 8'hFF); do_write(2'd2, 8'hFF);
    do_write(2'd0, 8'h81);
    do_write(2'd0, 8'h80);
    rd_chk("R6 clash write", 2'd0, 8'h80);
    do_write(2'd0, 8'h00);

    // read, confirm, bit-clear (no clash) - R7
    do_write(2'd1, 8'hFF); do_write(2'd2, 8'hFF);
    do_write(2'd0, 8'h80);
    @(negedge clk_i);
    rd_chk("R8 confirm", 2'd0, 8'h81);
    do_bclr(3'd0);
    rd_chk("R7 clear", 2'd0, 8'h80);
    do_write(2'd0, 8'h00);

    // R8 rollover in read phase
    do_write(2'd1, 8'hFF); do_write(2'd2, 8'hFF);
    do_write(2'd0, 8'h80);
    do_bclr(3'd0);
    rd_chk("R8 read phase", 2'd0, 8'h81);
    do_write(2'd0, 8'h01);
    do_bclr(3'd0);
    rd_chk("R7 clear", 2'd0, 8'h00);

    // R8 rollover in write phase
    do_write(2'd1, 8'hFE); do_write(2'd2, 8'hFF);
    do_write(2'd0, 8'h80);
    do_bclr(3'd0);
    rd_chk("R8 write phase", 2'd0, 8'h81);
    do_write(2'd0, 8'h01);

    // R9 byte write during write phase is dropped
    addr_i = 2'd0; bit_idx_i = 3'd0; bclr_i = 1'b1;
    @(negedge clk_i);
    bclr_i = 1'b0; wr_i = 1'b1; wdata_i = 8'h7E;
    @(negedge clk_i);
    wr_i = 1'b0;
    rd_chk("R9 ignored", 2'd0, 8'h00);

    // R7 other indices
    do_write(2'd0, 8'h2A);
    rd_chk("R4 after rmw", 2'd0, 8'h2A);
    do_bclr(3'd3);
    rd_chk("R7 bit3", 2'd0, 8'h22);
    do_write(2'd0, 8'hA2);
    do_bclr(3'd7);
    rd_chk("R7 bit7", 2'd0, 8'h22);
    addr_i = 2'd1; #1;
    wdata_i = rdata_o;
    repeat (3) @(negedge clk_i);
    rd_chk("R2 stopped", 2'd1, wdata_i);

    finish_run();
  end
endmodule